// File: doc/BRIEF.md
# Byte-in bit-out speech FIFO

This block buffers serial speech parameter data between a host and a frame parser. The host pushes bytes through a valid/ready port. The parser pulls the stream back one bit at a time. Sixteen bytes of storage give the parser a 128-bit serial window. Each byte is drained from its most significant bit down. After the eighth bit of the oldest byte is used, that byte is retired and the next oldest byte becomes the head.

A clear starts an external-speak session. It flushes the buffer, raises the interrupt request and arms the talk logic. Talking starts a programmable number of cycles after the buffer first holds nine bytes. It stops when the buffer runs dry, and that also ends the session. The block reports three status flags: fewer than nine bytes held, no bytes held, and talking. An active-low interrupt pulses on talk end and on status changes during a session. When the buffer is full, the ready signal is held low so that the host stalls.

Top module: `speech_fifo`

## Requirements
- R1: After reset, buf_empty_o=1, buf_low_o=1, talk_o=0, irq_no=1, bit_valid_o=0 and wr_ready_o=1.
- R2: Bits leave in write order, bit 7 of each byte first down to bit 0. Up to DEPTH=16 bytes (128 bits) are held.
- R3: wr_ready_o is 0 while 16 bytes are held. A write offered while ready is 0 is not taken.
- R4: buf_low_o is 1 exactly while fewer than 9 bytes are held. A byte counts as held until its eighth bit is consumed.
- R5: buf_empty_o is 1 exactly while 0 bytes are held.
- R6: In a session, the first edge at which at least 9 bytes are held starts a delay. talk_o rises START_DLY+1 cycles after the edge that stored the ninth byte.
- R7: bit_valid_o is 1 only while talking with bytes held. A bit is consumed on a clock edge where bit_req_i and bit_valid_o are both 1, and bit_o then moves to the next bit.
- R8: When talking with 0 bytes held, talk_o falls on the next edge and the session ends. Later writes do not restart talking until another clear.
- R9: clear_i empties the buffer, stops talking, opens a session and drives irq_no low for the next cycle. wr_ready_o is 0 during clear_i, so a write in that cycle is dropped.
- R10: irq_no is low for one cycle after an edge at which talk_o falls, or at which buf_low_o or buf_empty_o changes while in a session. Outside a session, flag changes leave irq_no high.
- R11: A byte write and the consumption of a byte's last bit in the same cycle leave the byte count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Flush buffer and open an external-speak session |
| wr_valid_i | input | 1 | Host byte offered |
| wr_data_i | input | 8 | Host byte |
| wr_ready_o | output | 1 | Byte accepted this cycle when valid |
| bit_req_i | input | 1 | Consumer takes the current bit |
| bit_valid_o | output | 1 | bit_o is meaningful |
| bit_o | output | 1 | Current serial bit |
| buf_low_o | output | 1 | Fewer than 9 bytes held |
| buf_empty_o | output | 1 | No bytes held |
| talk_o | output | 1 | Talk status |
| irq_no | output | 1 | Interrupt request pulse, active low |

## Verification
The bench targets the ninth-byte boundary and the exact cycle of talk start. A wrong threshold or an off-by-one delay shows up as a talk edge one cycle early or late. It also drives the full buffer with valid held high, so an overflow would corrupt the oldest byte and the serial stream. It aims simultaneous write and last-bit consume at the count, where a bad update leaves the flags wrong. Finally, it writes after a session has ended, where a design that leaves talk armed would start speaking or raise spurious interrupts.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  typedef enum logic [1:0] {
    TS_IDLE = 2'd0,
    TS_WAIT = 2'd1,
    TS_TALK = 2'd2
  } talk_st_e;
endpackage

// File: rtl/sfifo_store.sv
module sfifo_store #(
  parameter int DEPTH  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              push_i,
  input  logic [BYTE_W-1:0] push_data_i,
  input  logic              bit_adv_i,
  output logic              pop_o,
  output logic              head_bit_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int IDX_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;

  logic [BYTE_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q, wr_ptr_inc, rd_ptr_inc;
  logic [IDX_W-1:0]  idx_q;
  logic              last_bit;

  // pointer wrap: free-running for power-of-two depth, compare otherwise
  generate
    if ((1 << PTR_W) == DEPTH) begin : g_pow2
      assign wr_ptr_inc = wr_ptr_q + 1'b1;
      assign rd_ptr_inc = rd_ptr_q + 1'b1;
    end else begin : g_mod
      assign wr_ptr_inc = (wr_ptr_q == PTR_W'(DEPTH-1)) ? '0 : wr_ptr_q + 1'b1;
      assign rd_ptr_inc = (rd_ptr_q == PTR_W'(DEPTH-1)) ? '0 : rd_ptr_q + 1'b1;
    end
  endgenerate

  assign last_bit = (idx_q == IDX_W'(BYTE_W-1));
  assign pop_o    = bit_adv_i && last_bit;

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      idx_q    <= '0;
    end else if (clear_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      idx_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= wr_ptr_inc;
      if (bit_adv_i) begin
        idx_q <= last_bit ? '0 : idx_q + 1'b1;
        if (last_bit) rd_ptr_q <= rd_ptr_inc;
      end
    end
  end

  // MSB of the head byte goes first
  assign head_bit_o = mem_q[rd_ptr_q][IDX_W'(BYTE_W-1) - idx_q];
endmodule

// File: rtl/sfifo_level.sv
module sfifo_level #(
  parameter int DEPTH    = 16,
  parameter int LOW_MARK = 9,
  localparam int CNT_W   = $clog2(DEPTH+1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             push_i,
  input  logic             pop_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o,
  output logic             low_q_o,
  output logic             empty_q_o,
  output logic             low_d_o,
  output logic             empty_d_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (clear_i) cnt_d = '0;
    else         cnt_d = cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o     = cnt_q;
  assign full_o    = (cnt_q == CNT_W'(DEPTH));
  assign low_q_o   = (cnt_q < CNT_W'(LOW_MARK));
  assign empty_q_o = (cnt_q == '0);
  assign low_d_o   = (cnt_d < CNT_W'(LOW_MARK));
  assign empty_d_o = (cnt_d == '0);
endmodule

// File: rtl/sfifo_talk.sv
module sfifo_talk
  import sfifo_pkg::*;
#(
  parameter int START_DLY = 2500,
  localparam int DLY_W    = $clog2(START_DLY+1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic low_q_i,
  input  logic empty_q_i,
  input  logic low_d_i,
  input  logic empty_d_i,
  output logic talk_o,
  output logic irq_no
);
  talk_st_e         st_q, st_d;
  logic [DLY_W-1:0] dly_q, dly_d;
  logic             ext_q, ext_d;
  logic             evt, irq_n_q;

  always_comb begin
    st_d  = st_q;
    dly_d = dly_q;
    ext_d = ext_q;
    evt   = ext_q && ((low_d_i != low_q_i) || (empty_d_i != empty_q_i));
    if (clear_i) begin
      st_d  = TS_IDLE;
      dly_d = '0;
      ext_d = 1'b1;
      evt   = 1'b1;
    end else begin
      unique case (st_q)
        TS_IDLE: if (ext_q && !low_q_i) begin
          st_d  = TS_WAIT;
          dly_d = '0;
        end
        TS_WAIT: begin
          if (dly_q == DLY_W'(START_DLY-1)) st_d = TS_TALK;
          else                              dly_d = dly_q + 1'b1;
        end
        TS_TALK: if (empty_q_i) begin
          st_d  = TS_IDLE;
          ext_d = 1'b0;
          evt   = 1'b1;
        end
        default: st_d = TS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= TS_IDLE;
      dly_q   <= '0;
      ext_q   <= 1'b0;
      irq_n_q <= 1'b1;
    end else begin
      st_q    <= st_d;
      dly_q   <= dly_d;
      ext_q   <= ext_d;
      irq_n_q <= !evt;
    end
  end

  assign talk_o = (st_q == TS_TALK);
  assign irq_no = irq_n_q;
endmodule

// File: rtl/speech_fifo.sv
module speech_fifo #(
  parameter int DEPTH     = 16,
  parameter int BYTE_W    = 8,
  parameter int LOW_MARK  = 9,
  parameter int START_DLY = 2500
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              wr_valid_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic              wr_ready_o,
  input  logic              bit_req_i,
  output logic              bit_valid_o,
  output logic              bit_o,
  output logic              buf_low_o,
  output logic              buf_empty_o,
  output logic              talk_o,
  output logic              irq_no
);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [CNT_W-1:0] cnt_q;
  logic full, push, pop, bit_adv;
  logic low_q, empty_q, low_d, empty_d, talk;

  assign wr_ready_o  = !full && !clear_i;
  assign push        = wr_valid_i && wr_ready_o;
  assign bit_valid_o = talk && !empty_q;
  assign bit_adv     = bit_req_i && bit_valid_o && !clear_i;

  sfifo_store #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (clear_i),
    .push_i      (push),
    .push_data_i (wr_data_i),
    .bit_adv_i   (bit_adv),
    .pop_o       (pop),
    .head_bit_o  (bit_o)
  );

  sfifo_level #(.DEPTH(DEPTH), .LOW_MARK(LOW_MARK)) u_level (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (clear_i),
    .push_i    (push),
    .pop_i     (pop),
    .cnt_o     (cnt_q),
    .full_o    (full),
    .low_q_o   (low_q),
    .empty_q_o (empty_q),
    .low_d_o   (low_d),
    .empty_d_o (empty_d)
  );

  sfifo_talk #(.START_DLY(START_DLY)) u_talk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (clear_i),
    .low_q_i   (low_q),
    .empty_q_i (empty_q),
    .low_d_i   (low_d),
    .empty_d_i (empty_d),
    .talk_o    (talk),
    .irq_no    (irq_no)
  );

  assign talk_o      = talk;
  assign buf_low_o   = low_q;
  assign buf_empty_o = empty_q;
endmodule

// File: rtl/speech_fifo_chk.sv
module speech_fifo_chk #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH+1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clear_i,
  input logic             wr_ready_o,
  input logic             bit_valid_o,
  input logic             buf_low_o,
  input logic             buf_empty_o,
  input logic             talk_o,
  input logic             irq_no,
  input logic [CNT_W-1:0] cnt_q
);
  // R3
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  // R3
  full_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_W'(DEPTH)) |-> !wr_ready_o);
  // R5
  empty_is_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_empty_o |-> buf_low_o);
  // R9
  clear_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (buf_empty_o && !talk_o && !irq_no));
  // R10
  talk_fall_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(talk_o) |-> !irq_no);
  // R6
  talk_rise_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(talk_o) |-> !buf_low_o);
  // R8
  talk_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (talk_o && buf_empty_o && !clear_i) |=> !talk_o);
  // R7
  bit_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |-> !buf_empty_o);
endmodule

bind speech_fifo speech_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .clear_i     (clear_i),
  .wr_ready_o  (wr_ready_o),
  .bit_valid_o (bit_valid_o),
  .buf_low_o   (buf_low_o),
  .buf_empty_o (buf_empty_o),
  .talk_o      (talk_o),
  .irq_no      (irq_no),
  .cnt_q       (cnt_q)
);

// File: tb/sim_speech_fifo.sv
`timescale 1ns/1ps
module sim_speech_fifo;
  localparam int DLY = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0, wv = 1'b0, rq = 1'b0;
  logic [7:0] wd = '0;
  logic ready, bvalid, bout, low, empty, talk, irq_n;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  speech_fifo #(.START_DLY(DLY)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clr),
    .wr_valid_i(wv), .wr_data_i(wd), .wr_ready_o(ready),
    .bit_req_i(rq), .bit_valid_o(bvalid), .bit_o(bout),
    .buf_low_o(low), .buf_empty_o(empty), .talk_o(talk), .irq_no(irq_n)
  );

  // reference model
  bit m_bits[$];
  int m_st  = 0;   // 0 idle, 1 wait, 2 talk
  int m_dly = 0;
  bit m_ext = 0;
  bit m_irq_n = 1;

  function automatic int m_cnt();
    return (m_bits.size() + 7) / 8;
  endfunction

  function automatic bit exp_ready();
    return (m_cnt() < 16) && !clr;
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      int  c0;
      bit  fw, fr, evt, l0, e0;
      c0 = m_cnt();
      l0 = c0 < 9;
      e0 = c0 == 0;
      fw = wv && exp_ready();
      fr = rq && (m_st == 2) && (c0 > 0);
      evt = 0;
      if (clr) begin
        m_bits.delete();
        m_st = 0; m_dly = 0; m_ext = 1; evt = 1;
      end else begin
        if (fr) void'(m_bits.pop_front());
        if (fw) for (int i = 7; i >= 0; i--) m_bits.push_back(wd[i]);
        if (m_ext && (((m_cnt() < 9) != l0) || ((m_cnt() == 0) != e0))) evt = 1;
        if (m_st == 2 && e0) begin
          m_st = 0; m_ext = 0; evt = 1;
        end else if (m_st == 0 && m_ext && !l0) begin
          m_st = 1; m_dly = 0;
        end else if (m_st == 1) begin
          if (m_dly == DLY - 1) m_st = 2;
          else m_dly++;
        end
      end
      m_irq_n = !evt;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_regs();
    int c;
    c = m_cnt();
    check("R4 buf_low", low, c < 9);
    check("R5 buf_empty", empty, c == 0);
    check("R6 talk", talk, m_st == 2);
    check("R7 bit_valid", bvalid, (m_st == 2) && (c > 0));
    check("R10 irq_n", irq_n, m_irq_n);
    if ((m_st == 2) && (c > 0)) check("R2 bit_o", bout, m_bits[0]);
  endtask

  task automatic step(bit c, bit v, logic [7:0] d, bit r);
    @(negedge clk);
    check_regs();
    clr = c; wv = v; wd = d; rq = r;
    #1;
    check("R3 wr_ready", ready, exp_ready());
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 8'h00, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5220));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 empty", empty, 1); check("R1 low", low, 1);
    check("R1 talk", talk, 0);   check("R1 irq_n", irq_n, 1);
    check("R1 bit_valid", bvalid, 0); check("R1 ready", ready, 1);
    rst_n = 1'b1;

    // R10: writes outside a session raise no interrupt
    for (int i = 0; i < 10; i++) step(0, 1, 8'(i), 0);
    idle(DLY + 4);
    check("R8 no talk outside session", talk, 0);

    // R9 clear opens session; R6 ninth byte starts delay
    step(1, 0, 0, 0);
    for (int i = 0; i < 9; i++) step(0, 1, 8'hA5 ^ 8'(i), 0);
    idle(DLY + 3);
    check("R6 talk after delay", talk, 1);

    // R3 fill and push against full
    for (int i = 0; i < 7; i++) step(0, 1, 8'h3C + 8'(i), 0);
    for (int i = 0; i < 4; i++) step(0, 1, 8'hFF, 0);
    check("R3 full stall", ready, 0);

    // R11 concurrent write and consume; R2 order
    for (int i = 0; i < 60; i++) step(0, 1, 8'($urandom), 1);

    // R8 drain to empty ends talking and session
    while (m_cnt() > 0) step(0, 0, 0, 1);
    idle(3);
    check("R8 talk ended", talk, 0);
    for (int i = 0; i < 10; i++) step(0, 1, 8'($urandom), 0);
    idle(DLY + 4);
    check("R8 no restart", talk, 0);

    // R9 clear during talk with a write offered
    step(1, 0, 0, 0);
    for (int i = 0; i < 12; i++) step(0, 1, 8'($urandom), 0);
    idle(DLY + 3);
    step(0, 0, 0, 1);
    step(1, 1, 8'h77, 1);
    step(0, 0, 0, 0);
    check("R9 cleared empty", empty, 1);

    // random mix
    for (int i = 0; i < 5000; i++)
      step(($urandom % 300) == 0, ($urandom % 100) < 45, 8'($urandom),
           ($urandom % 100) < 65);
    idle(2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule